// File: doc/BRIEF.md
# Dithered Counter-Based Digital Pulse-Width Modulator

This block turns a digital duty command into the switch-control waveform of a switching power converter. A counter runs on a fast clock and covers one switching period in 2^CNT_W counts. The output rises when a period starts. It falls once the counter reaches the period's duty code. One code step is therefore 1/2^CNT_W of the period.

The duty command carries two extra low bits below the coarse code. These bits are resolved in time over a frame of four switching periods. Some periods use the coarse code plus one, and the rest use the coarse code. The frame average then lands a quarter, half or three quarters of a step above the coarse value, which gives four times finer mean resolution. A mode input chooses how the raised periods sit in the frame. In clustered mode they are grouped, which gives a fixed ripple tone. In spread mode they are interleaved, which gives a higher and varying ripple tone of smaller amplitude.

The command and the mode are captured only when a frame begins, so one frame never mixes two commands. A one-cycle strobe marks the start of every period.

Top module: `dpwm_dither`

## Requirements
- R1: While enabled, `period_start` is high for exactly one fast-clock cycle, when the counter is zero. Successive strobes are exactly 2^CNT_W cycles apart.
- R2: In each period, `pwm` is high for the first C cycles and low for the remaining cycles, where C is the applied code for that period.
- R3: Periods are grouped into frames of four, numbered slot 0 to 3 from the first strobe after enabling. The fraction f = `duty[1:0]` sets how many slots use coarse+1, where coarse = `duty[CNT_W+1:2]`. When not saturated, the high-cycle total over a frame is 4*coarse+f.
- R4: With `mode`=0 (clustered), the raised periods are the first f slots of the frame.
- R5: With `mode`=1 (spread), the raised slots are: slot 0 for f=1; slots 0 and 2 for f=2; slots 0, 1 and 2 for f=3.
- R6: `duty` and `mode` are sampled only at the clock edge that starts a frame. Changes at any other time do not affect the current frame.
- R7: A coarse code of 0 with f=0 keeps `pwm` low through the whole frame.
- R8: A coarse code of all ones makes every period use the all-ones code (2^CNT_W-1 high cycles), whatever f is.
- R9: When `en` is sampled low, `pwm` and `period_start` are low from the next cycle on, and the frame restarts. On the first edge where `en` is sampled high again, the command is captured, and `period_start` is high in the following cycle, which is slot 0.
- R10: While `rst_n` is low, `pwm` and `period_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the output off and restarts the frame |
| mode | input | 1 | Dither placement: 0 clustered, 1 spread |
| duty | input | CNT_W+2 | Duty command: coarse code in the upper CNT_W bits, two fraction bits below |
| pwm | output | 1 | Pulse-width modulated switch control |
| period_start | output | 1 | One-cycle strobe at the start of each switching period |

## Verification
The assertions assume that `en`, `mode` and `duty` are synchronous to `clk`. They also assume that reset is applied before the first edge they judge. Given that, the properties can treat the sampled command as stable over the edge that captures it. The stimulus changes every input only on the falling clock edge, so each rising edge sees settled values. Random command and mode changes land anywhere inside a frame, so the frame-boundary capture is exercised. Enable drops are timed at random and cut periods short.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
   localparam int FRAME_W   = 2;
   localparam int FRAME_LEN = 1 << FRAME_W;

   typedef logic [FRAME_W-1:0] slot_t;

   typedef enum logic {
      PAT_CLUSTER = 1'b0,
      PAT_SPREAD  = 1'b1
   } dither_pat_e;
endpackage

// File: rtl/dpwm_period_ctr.sv
module dpwm_period_ctr #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(1);
   end

   assign wrap = run && (cnt == CNT_MAX);
endmodule

// File: rtl/dpwm_frame_seq.sv
module dpwm_frame_seq
   import dpwm_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             wrap,
   input  logic [CNT_W+1:0] duty,
   input  logic             mode,
   output logic             running,
   output slot_t            slot,
   output logic             latch_now,
   output logic [CNT_W-1:0] coarse_q,
   output logic [1:0]       frac_q,
   output dither_pat_e      pat_q
);
   localparam slot_t SLOT_LAST = slot_t'(FRAME_LEN - 1);

   logic frame_end;

   assign frame_end = running && wrap && (slot == SLOT_LAST);
   assign latch_now = en && (!running || frame_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         slot    <= '0;
      end else if (!en) begin
         running <= 1'b0;
         slot    <= '0;
      end else if (!running) begin
         running <= 1'b1;
         slot    <= '0;
      end else if (wrap) begin
         slot    <= slot + slot_t'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         coarse_q <= '0;
         frac_q   <= '0;
         pat_q    <= PAT_CLUSTER;
      end else if (latch_now) begin
         coarse_q <= duty[CNT_W+1:2];
         frac_q   <= duty[1:0];
         pat_q    <= dither_pat_e'(mode);
      end
   end
endmodule

// File: rtl/dpwm_dither_code.sv
module dpwm_dither_code
   import dpwm_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic [CNT_W-1:0] coarse,
   input  logic [1:0]       frac,
   input  slot_t            slot,
   input  dither_pat_e      pat,
   output logic [CNT_W-1:0] code
);
   slot_t slot_rev;
   slot_t rank;
   logic  bump;
   logic  at_top;

   for (genvar i = 0; i < FRAME_W; i++) begin : g_rev
      assign slot_rev[i] = slot[FRAME_W-1-i];
   end

   assign rank   = (pat == PAT_SPREAD) ? slot_rev : slot;
   assign bump   = (rank < frac);
   assign at_top = &coarse;

   always_comb begin
      if (bump && !at_top)
         code = coarse + CNT_W'(1);
      else
         code = coarse;
   end
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither
   import dpwm_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             mode,
   input  logic [CNT_W+1:0] duty,
   output logic             pwm,
   output logic             period_start
);
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("dpwm_dither: CNT_W must lie in 2..16");
   end

   logic             running;
   logic             wrap;
   logic             latch_now;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] coarse_q;
   logic [1:0]       frac_q;
   dither_pat_e      pat_q;
   slot_t            slot;
   logic [CNT_W-1:0] code;

   dpwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (running),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   dpwm_frame_seq #(.CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .wrap      (wrap),
      .duty      (duty),
      .mode      (mode),
      .running   (running),
      .slot      (slot),
      .latch_now (latch_now),
      .coarse_q  (coarse_q),
      .frac_q    (frac_q),
      .pat_q     (pat_q)
   );

   dpwm_dither_code #(.CNT_W(CNT_W)) u_code (
      .coarse (coarse_q),
      .frac   (frac_q),
      .slot   (slot),
      .pat    (pat_q),
      .code   (code)
   );

   assign pwm          = running && (cnt < code);
   assign period_start = running && (cnt == '0);
endmodule

// File: rtl/dpwm_dither_chk.sv
module dpwm_dither_chk
   import dpwm_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic             pwm,
   input logic             period_start,
   input logic             running,
   input logic             latch_now,
   input slot_t            slot,
   input logic [CNT_W-1:0] coarse_q,
   input logic [CNT_W-1:0] code
);
   localparam int               PERIOD  = 1 << CNT_W;
   localparam logic [CNT_W:0]   GAP_END = (CNT_W+1)'(PERIOD - 1);

   logic [CNT_W:0] gap;
   logic           seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (!running) begin
         gap  <= '0;
         seen <= 1'b0;
      end else if (period_start) begin
         gap  <= '0;
         seen <= 1'b1;
      end else begin
         gap  <= gap + (CNT_W+1)'(1);
      end
   end

   a_r1_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      period_start |=> !period_start);

   a_r1_period_len: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start && seen) |-> (gap == GAP_END));

   a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm) |-> period_start);

   a_r3_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !period_start) |-> $stable(slot));

   a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_now |=> $stable(coarse_q));

   a_r7_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (code == '0) |-> !pwm);

   a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (&coarse_q) |-> (code == coarse_q));

   a_r9_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!pwm && !period_start));

   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !running) |=> period_start);
endmodule

bind dpwm_dither dpwm_dither_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .en           (en),
   .pwm          (pwm),
   .period_start (period_start),
   .running      (running),
   .latch_now    (latch_now),
   .slot         (slot),
   .coarse_q     (coarse_q),
   .code         (code)
);

// File: tb/sim_dpwm_dither.sv
`timescale 1ns/1ps
module sim_dpwm_dither;
   localparam int CNT_W = 4;
   localparam int DW    = CNT_W + 2;
   localparam int P     = 1 << CNT_W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0;
   logic          mode = 1'b0;
   logic [DW-1:0] duty = '0;
   logic          pwm;
   logic          period_start;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   dpwm_dither #(.CNT_W(CNT_W)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .mode         (mode),
      .duty         (duty),
      .pwm          (pwm),
      .period_start (period_start)
   );

   always #2 clk = ~clk;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_code(input int c, input int f, input logic [1:0] s, input bit m);
      logic [1:0] r;
      r = m ? {s[0], s[1]} : s;
      if (c == P - 1) return c;
      return (int'(r) < f) ? c + 1 : c;
   endfunction

   function automatic string tag_of(input int c, input int f, input bit m, input bit moved);
      if (c == P - 1)         return "R8";
      if (c == 0 && f == 0)   return "R7";
      if (moved)              return "R6";
      if (f == 0)             return "R2";
      return m ? "R5" : "R4";
   endfunction

   bit         in_per = 1'b0;
   bit         prev_en = 1'b0;
   bit         moved = 1'b0;
   logic [1:0] slot = '0;
   int         lc = 0, lf = 0;
   bit         lm = 1'b0;
   int         hi = 0, len = 0, fsum = 0;

   task automatic finish_period();
      int e;
      e = exp_code(lc, lf, slot, lm);
      check(len == P, "R1", len, P);
      check(hi == e, tag_of(lc, lf, lm, moved), hi, e);
      fsum += hi;
      if (slot == 2'd3) begin
         e = (lc == P - 1) ? 4 * lc : 4 * lc + lf;
         check(fsum == e, "R3", fsum, e);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (!done) begin
         if (!rst_n) begin
            check(!pwm && !period_start, "R10", {pwm, period_start}, 0);
            in_per = 1'b0;
         end else if (!en) begin
            check(!pwm && !period_start, "R9", {pwm, period_start}, 0);
            in_per = 1'b0;
         end else begin
            if (!prev_en)
               check(period_start == 1'b1, "R9", period_start, 1);
            if (period_start) begin
               if (in_per) finish_period();
               slot = in_per ? slot + 2'd1 : 2'd0;
               if (slot == 2'd0) begin
                  lc    = int'(duty[DW-1:2]);
                  lf    = int'(duty[1:0]);
                  lm    = mode;
                  fsum  = 0;
                  moved = 1'b0;
               end
               in_per = 1'b1;
               hi     = int'(pwm);
               len    = 1;
            end else if (in_per) begin
               hi  += int'(pwm);
               len += 1;
            end
            if (int'(duty[DW-1:2]) != lc || int'(duty[1:0]) != lf || mode != lm)
               moved = 1'b1;
         end
         prev_en = rst_n && en;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic apply(input int c, input int f, input bit m, input int frames);
      @(negedge clk);
      duty = DW'((c << 2) | f);
      mode = m;
      cycles(frames * 4 * P + 2);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      cycles(4);
      rst_n = 1'b1;
      cycles(2);
      en = 1'b1;
      // directed corners: R7, R8, R4, R5
      apply(0, 0, 1'b0, 2);
      apply(P - 1, 2, 1'b1, 2);
      apply(P - 1, 0, 1'b0, 2);
      apply(0, 3, 1'b0, 2);
      apply(5, 1, 1'b0, 2);
      apply(5, 2, 1'b0, 2);
      apply(5, 3, 1'b0, 2);
      apply(9, 1, 1'b1, 2);
      apply(9, 2, 1'b1, 2);
      apply(9, 3, 1'b1, 2);
      apply(P - 2, 3, 1'b1, 2);
      // enable drop and restart (R9)
      @(negedge clk);
      en = 1'b0;
      cycles(5);
      en = 1'b1;
      cycles(3 * 4 * P);
      // random phase: mid-frame changes (R6) and random enable drops
      for (int i = 0; i < 300; i++) begin
         cycles(1 + ($urandom % 80));
         duty = DW'($urandom);
         mode = 1'($urandom);
         if (($urandom % 20) == 0) begin
            en = 1'b0;
            cycles(1 + ($urandom % 6));
            en = 1'b1;
         end
      end
      cycles(5 * 4 * P);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule